// File: doc/BRIEF.md
# Memory Access Ordering Queue

This block sits between issue and the data-memory port of an out-of-order core. It holds every in-flight load and store in program order, in a circular queue of slots. The front end reserves a slot when it issues a memory operation. The slot index is returned as the operation's tag. The address unit reports the effective address later, against that tag, and in any order. Stores report their write data separately, also against their tag. Each cycle the queue compares the resolved addresses of all entries with those of the entries older than them. It then sends the oldest entry that may safely go to the single memory port.

A load may pass older accesses once every older store has a known address that differs from its own. With forwarding built in, a load whose address matches an older store takes the data of the youngest such store. That data comes straight from the queue, and the load makes no memory read. A store must wait until every older access has a known address and every older access to its address has finished. Entries complete out of order. They leave the queue in order, from the head, when the retire input asks.

Top module: `mem_order_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `retire_ready`, `mem_req_valid` and `ld_res_valid` are 0.
- R2: Tags are slot indices handed out in consecutive order, wrapping at DEPTH. `alloc_ready` is 0 while DEPTH entries are held, and an allocation offered while full is ignored.
- R3: A load is never sent while any older store has no address yet.
- R4: Without forwarding, a load whose address equals that of an older store is not sent until that store's write has been sent.
- R5: With forwarding, a load whose address equals that of one or more older stores produces no memory request. It returns the data of the youngest such store on the result port with `ld_res_fwd`=1. It stalls while that store's data is missing.
- R6: A store is sent only once all of the following hold: its own address and data are known, every older entry has an address, and every older entry to the same address has completed.
- R7: An access whose address differs from every older unresolved conflict may be sent ahead of older, blocked entries.
- R8: At most one entry acts per cycle, either as a memory request or as a forwarded result, and the oldest eligible entry wins. A request appears on `mem_req_*` in the cycle after the decision. `mem_req_write`=1 marks a store.
- R9: A memory response for tag T gives `ld_res_valid`=1 with tag T, the response data and `ld_res_fwd`=0 in the next cycle.
- R10: `retire_ready` is 1 when the head entry is complete: a store whose write was sent, or a load whose result was delivered. `retire_valid` with `retire_ready` frees the head slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Reserve a slot for the next memory operation |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | log2(DEPTH) | Tag the next allocation receives |
| addr_valid | input | 1 | Address report |
| addr_tag | input | log2(DEPTH) | Entry the address belongs to |
| addr_value | input | AW | Word address |
| sdata_valid | input | 1 | Store data report |
| sdata_tag | input | log2(DEPTH) | Store the data belongs to |
| sdata_value | input | DW | Store data |
| mem_req_valid | output | 1 | Memory request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_req_tag | output | log2(DEPTH) | Tag of requesting entry |
| mem_rsp_valid | input | 1 | Read data returns |
| mem_rsp_tag | input | log2(DEPTH) | Tag of the read |
| mem_rsp_data | input | DW | Read data |
| ld_res_valid | output | 1 | Load result |
| ld_res_tag | output | log2(DEPTH) | Load tag |
| ld_res_data | output | DW | Load data |
| ld_res_fwd | output | 1 | Data came from an older store in the queue |
| retire_valid | input | 1 | Free the head entry |
| retire_ready | output | 1 | Head entry is complete |

## Verification
The bench builds two copies side by side with DEPTH=4, AW=8 and DW=16, one with FWD_EN=1 and one with FWD_EN=0, and drives both with the same stimulus. The shallow queue fills after four allocations, so the full condition and pointer wrap are easy to reach. Running the two copies together puts forwarding and wait-for-write side by side on identical traffic. The youngest-of-several-matching-stores case and a read overtaking a stalled store are both exercised.

// File: rtl/moq_pkg.sv
package moq_pkg;

  // Per-slot status bits
  typedef struct packed {
    logic busy;   // slot holds an operation
    logic is_st;  // store when set
    logic a_ok;   // address known
    logic d_ok;   // store data known
    logic sent;   // granted (request or forward)
    logic fin;    // store write sent / load result delivered
  } moq_flags_t;

endpackage

// File: rtl/moq_elig.sv
module moq_elig #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter bit FWD_EN = 1'b1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0]             head,
  input  logic [DEPTH-1:0]          busy,
  input  logic [DEPTH-1:0]          is_st,
  input  logic [DEPTH-1:0]          a_ok,
  input  logic [DEPTH-1:0]          d_ok,
  input  logic [DEPTH-1:0]          sent,
  input  logic [DEPTH-1:0]          fin,
  input  logic [DEPTH-1:0][AW-1:0]  addr,
  input  logic                      rsp_busy,
  output logic [DEPTH-1:0]          go_mem,
  output logic [DEPTH-1:0]          go_fwd,
  output logic [DEPTH-1:0][IW-1:0]  src
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          blk_a;   // an older relevant entry lacks an address
    logic          blk_m;   // an older same-address entry is not finished
    logic          have;    // an older same-address store exists
    logic [IW-1:0] s_idx;
    logic [IW-1:0] s_rank;
    logic [IW-1:0] ri;
    logic [IW-1:0] rj;
    logic          base;

    always_comb begin
      blk_a  = 1'b0;
      blk_m  = 1'b0;
      have   = 1'b0;
      s_idx  = '0;
      s_rank = '0;
      rj     = '0;
      ri     = IW'(i) - head;
      for (int j = 0; j < DEPTH; j++) begin
        rj = IW'(j) - head;
        if (j != i && busy[j] && rj < ri) begin
          if (!a_ok[j] && (is_st[i] || is_st[j]))
            blk_a = 1'b1;
          if (a_ok[j] && addr[j] == addr[i]) begin
            if (is_st[i] && !fin[j])
              blk_m = 1'b1;
            if (!is_st[i] && is_st[j]) begin
              if (!fin[j])
                blk_m = 1'b1;
              if (!have || rj > s_rank) begin
                have   = 1'b1;
                s_idx  = IW'(j);
                s_rank = rj;
              end
            end
          end
        end
      end
    end

    assign base   = busy[i] & a_ok[i] & ~sent[i];
    assign src[i] = s_idx;

    if (FWD_EN) begin : g_fwd
      assign go_mem[i] = is_st[i] ? (base & d_ok[i] & ~blk_a & ~blk_m)
                                  : (base & ~blk_a & ~have);
      assign go_fwd[i] = ~is_st[i] & base & ~blk_a & have & d_ok[s_idx] & ~rsp_busy;
    end else begin : g_nofwd
      assign go_mem[i] = is_st[i] ? (base & d_ok[i] & ~blk_a & ~blk_m)
                                  : (base & ~blk_a & ~blk_m);
      assign go_fwd[i] = 1'b0;
    end
  end

endmodule

// File: rtl/moq_pick.sv
module moq_pick #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] want,
  input  logic [IW-1:0]    head,
  output logic             hit,
  output logic [IW-1:0]    idx
);

  logic [IW-1:0] k;

  // Scan from the head so the first hit is the oldest.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    k   = '0;
    for (int r = 0; r < DEPTH; r++) begin
      k = head + IW'(r);
      if (!hit && want[k]) begin
        hit = 1'b1;
        idx = k;
      end
    end
  end

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit FWD_EN = 1'b1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic          alloc_store,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          addr_valid,
  input  logic [IW-1:0] addr_tag,
  input  logic [AW-1:0] addr_value,
  input  logic          sdata_valid,
  input  logic [IW-1:0] sdata_tag,
  input  logic [DW-1:0] sdata_value,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  output logic [IW-1:0] mem_req_tag,
  input  logic          mem_rsp_valid,
  input  logic [IW-1:0] mem_rsp_tag,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ld_res_valid,
  output logic [IW-1:0] ld_res_tag,
  output logic [DW-1:0] ld_res_data,
  output logic          ld_res_fwd,
  input  logic          retire_valid,
  output logic          retire_ready
);
  import moq_pkg::*;

  localparam int CW = IW + 1;

  moq_flags_t    flg [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [IW-1:0] head, tail;
  logic [CW-1:0] count;

  logic [DEPTH-1:0]         v_busy, v_st, v_aok, v_dok, v_sent, v_fin;
  logic [DEPTH-1:0][AW-1:0] v_addr;
  logic [DEPTH-1:0]         go_mem, go_fwd;
  logic [DEPTH-1:0][IW-1:0] fsrc;
  logic                     g_hit;
  logic [IW-1:0]            g_idx;
  logic                     do_alloc, do_retire, g_fwd;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      v_busy[k] = flg[k].busy;
      v_st[k]   = flg[k].is_st;
      v_aok[k]  = flg[k].a_ok;
      v_dok[k]  = flg[k].d_ok;
      v_sent[k] = flg[k].sent;
      v_fin[k]  = flg[k].fin;
      v_addr[k] = addr_q[k];
    end
  end

  assign alloc_ready  = (count != CW'(DEPTH));
  assign alloc_tag    = tail;
  assign retire_ready = flg[head].busy & flg[head].fin;
  assign do_alloc     = alloc_valid & alloc_ready;
  assign do_retire    = retire_valid & retire_ready;

  moq_elig #(.DEPTH(DEPTH), .AW(AW), .FWD_EN(FWD_EN)) u_elig (
    .head(head), .busy(v_busy), .is_st(v_st), .a_ok(v_aok), .d_ok(v_dok),
    .sent(v_sent), .fin(v_fin), .addr(v_addr), .rsp_busy(mem_rsp_valid),
    .go_mem(go_mem), .go_fwd(go_fwd), .src(fsrc)
  );

  moq_pick #(.DEPTH(DEPTH)) u_pick (
    .want(go_mem | go_fwd), .head(head), .hit(g_hit), .idx(g_idx)
  );

  assign g_fwd = go_fwd[g_idx];

  // Address and data storage: no reset, written by tag
  always_ff @(posedge clk) begin
    if (addr_valid) addr_q[addr_tag] <= addr_value;
    if (sdata_valid) data_q[sdata_tag] <= sdata_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) flg[k] <= '0;
      head          <= '0;
      tail          <= '0;
      count         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      mem_req_tag   <= '0;
      ld_res_valid  <= 1'b0;
      ld_res_tag    <= '0;
      ld_res_data   <= '0;
      ld_res_fwd    <= 1'b0;
    end else begin
      mem_req_valid <= 1'b0;
      ld_res_valid  <= 1'b0;
      ld_res_fwd    <= 1'b0;

      if (do_alloc) begin
        flg[tail]       <= '0;
        flg[tail].busy  <= 1'b1;
        flg[tail].is_st <= alloc_store;
        tail            <= tail + 1'b1;
      end
      if (addr_valid) flg[addr_tag].a_ok <= 1'b1;
      if (sdata_valid) flg[sdata_tag].d_ok <= 1'b1;

      if (g_hit) begin
        flg[g_idx].sent <= 1'b1;
        if (g_fwd) begin
          flg[g_idx].fin <= 1'b1;
          ld_res_valid   <= 1'b1;
          ld_res_fwd     <= 1'b1;
          ld_res_tag     <= g_idx;
          ld_res_data    <= data_q[fsrc[g_idx]];
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_write <= flg[g_idx].is_st;
          mem_req_addr  <= addr_q[g_idx];
          mem_req_wdata <= data_q[g_idx];
          mem_req_tag   <= g_idx;
          if (flg[g_idx].is_st) flg[g_idx].fin <= 1'b1;
        end
      end

      if (mem_rsp_valid) begin
        flg[mem_rsp_tag].fin <= 1'b1;
        ld_res_valid <= 1'b1;
        ld_res_fwd   <= 1'b0;
        ld_res_tag   <= mem_rsp_tag;
        ld_res_data  <= mem_rsp_data;
      end

      if (do_retire) begin
        flg[head].busy <= 1'b0;
        head           <= head + 1'b1;
      end

      count <= count + CW'(do_alloc) - CW'(do_retire);
    end
  end

endmodule

// File: rtl/moq_chk.sv
module moq_chk #(
  parameter int IW = 3,
  parameter bit FWD_EN = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [IW-1:0] alloc_tag,
  input logic          retire_valid,
  input logic          retire_ready,
  input logic          mem_req_valid,
  input logic          mem_rsp_valid,
  input logic [IW-1:0] mem_rsp_tag,
  input logic          ld_res_valid,
  input logic [IW-1:0] ld_res_tag,
  input logic          ld_res_fwd
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!mem_req_valid && !ld_res_valid && alloc_ready && !retire_ready));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_ready) |=> $stable(alloc_tag));

  // R8
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req_valid && ld_res_valid && ld_res_fwd));

  // R9
  rsp_result_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |=> (ld_res_valid && !ld_res_fwd && ld_res_tag == $past(mem_rsp_tag)));

  // R10
  retire_free_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && retire_ready && !alloc_valid) |=> alloc_ready);

  // R4
  no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (!FWD_EN && ld_res_valid) |-> !ld_res_fwd);

endmodule

bind mem_order_queue moq_chk #(.IW(IW), .FWD_EN(FWD_EN)) u_moq_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .retire_valid(retire_valid), .retire_ready(retire_ready),
  .mem_req_valid(mem_req_valid), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_tag(mem_rsp_tag), .ld_res_valid(ld_res_valid), .ld_res_tag(ld_res_tag),
  .ld_res_fwd(ld_res_fwd)
);

// File: tb/mem_order_queue_bench.sv
`timescale 1ns/1ps
module mem_order_queue_bench;

  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          alloc_valid = 0, alloc_store = 0, addr_valid = 0, sdata_valid = 0, retire_valid = 0;
  logic [IW-1:0] addr_tag = 0, sdata_tag = 0;
  logic [AW-1:0] addr_value = 0;
  logic [DW-1:0] sdata_value = 0;

  // forwarding copy (f_) and non-forwarding copy (n_)
  logic f_ar, f_rr, f_qv, f_qw, f_rv, f_rf, f_sv;
  logic n_ar, n_rr, n_qv, n_qw, n_rv, n_rf, n_sv;
  logic [IW-1:0] f_at, f_qt, f_rt, f_st, n_at, n_qt, n_rt, n_st;
  logic [AW-1:0] f_qa, n_qa;
  logic [DW-1:0] f_qd, f_rd, f_sd, n_qd, n_rd, n_sd;

  mem_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .FWD_EN(1'b1)) u_mem_order_queue (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_store(alloc_store),
    .alloc_ready(f_ar), .alloc_tag(f_at), .addr_valid(addr_valid), .addr_tag(addr_tag),
    .addr_value(addr_value), .sdata_valid(sdata_valid), .sdata_tag(sdata_tag),
    .sdata_value(sdata_value), .mem_req_valid(f_qv), .mem_req_write(f_qw),
    .mem_req_addr(f_qa), .mem_req_wdata(f_qd), .mem_req_tag(f_qt),
    .mem_rsp_valid(f_sv), .mem_rsp_tag(f_st), .mem_rsp_data(f_sd),
    .ld_res_valid(f_rv), .ld_res_tag(f_rt), .ld_res_data(f_rd), .ld_res_fwd(f_rf),
    .retire_valid(retire_valid), .retire_ready(f_rr));

  mem_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .FWD_EN(1'b0)) u_mem_order_queue_nf (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_store(alloc_store),
    .alloc_ready(n_ar), .alloc_tag(n_at), .addr_valid(addr_valid), .addr_tag(addr_tag),
    .addr_value(addr_value), .sdata_valid(sdata_valid), .sdata_tag(sdata_tag),
    .sdata_value(sdata_value), .mem_req_valid(n_qv), .mem_req_write(n_qw),
    .mem_req_addr(n_qa), .mem_req_wdata(n_qd), .mem_req_tag(n_qt),
    .mem_rsp_valid(n_sv), .mem_rsp_tag(n_st), .mem_rsp_data(n_sd),
    .ld_res_valid(n_rv), .ld_res_tag(n_rt), .ld_res_data(n_rd), .ld_res_fwd(n_rf),
    .retire_valid(retire_valid), .retire_ready(n_rr));

  int total = 0, bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory models: answer a read one cycle after the request
  logic [DW-1:0] fmem [16];
  logic [DW-1:0] nmem [16];
  initial begin
    for (int a = 0; a < 16; a++) begin
      fmem[a] = DW'(16'h0100 + a);
      nmem[a] = DW'(16'h0100 + a);
    end
    f_sv = 0; f_st = 0; f_sd = 0; n_sv = 0; n_st = 0; n_sd = 0;
    forever begin
      @(negedge clk);
      f_sv = 0; n_sv = 0;
      if (!rst && f_qv) begin
        if (f_qw) fmem[f_qa[3:0]] = f_qd;
        else begin f_sv = 1; f_st = f_qt; f_sd = fmem[f_qa[3:0]]; end
      end
      if (!rst && n_qv) begin
        if (n_qw) nmem[n_qa[3:0]] = n_qd;
        else begin n_sv = 1; n_st = n_qt; n_sd = nmem[n_qa[3:0]]; end
      end
    end
  end

  // Event recorder
  logic rec = 0;
  int fq_n = 0, fr_n = 0, nq_n = 0, nr_n = 0;
  logic [IW-1:0] fq_t [8];
  logic [IW-1:0] nq_t [8];
  logic          nq_w [8];
  logic [DW-1:0] fr_d [8];
  logic          fr_f [8];
  logic [DW-1:0] nr_d [8];
  logic          nr_f [8];
  initial forever begin
    @(posedge clk); #1;
    if (rec) begin
      if (f_qv && fq_n < 8) begin fq_t[fq_n] = f_qt; fq_n++; end
      if (n_qv && nq_n < 8) begin nq_t[nq_n] = n_qt; nq_w[nq_n] = n_qw; nq_n++; end
      if (f_rv && fr_n < 8) begin fr_d[fr_n] = f_rd; fr_f[fr_n] = f_rf; fr_n++; end
      if (n_rv && nr_n < 8) begin nr_d[nr_n] = n_rd; nr_f[nr_n] = n_rf; nr_n++; end
    end
  end

  typedef struct packed {
    logic av; logic ast; logic adv; logic [1:0] atag; logic [7:0] aval;
    logic sdv; logic [1:0] stag; logic [15:0] sval; logic ret;
    logic ar; logic rr;
    logic qv; logic qw; logic [7:0] qa; logic [1:0] qt; logic [15:0] qd;
    logic rv; logic [1:0] rt; logic [15:0] rd; logic rf;
    logic nqv; logic nqw; logic [1:0] nqt;
    logic nrv; logic [1:0] nrt; logic [15:0] nrd;
  } row_t;

  // Stimulus and results after the same edge. R3: rows 2-4 hold loads
  // behind store tag 0 whose address is still unknown.
  localparam row_t TBL [14] = '{
    '{av:1, ast:1, ar:1, default:'0},
    '{av:1, ar:1, default:'0},
    '{av:1, adv:1, atag:1, aval:8'd5, ar:1, default:'0},
    '{av:1, ast:1, adv:1, atag:2, aval:8'd7, default:'0},
    '{adv:1, atag:0, aval:8'd5, default:'0},
    '{qv:1, qa:8'd7, qt:2, nqv:1, nqt:2, default:'0},
    '{sdv:1, stag:0, sval:16'hAAAA, rv:1, rt:2, rd:16'h0107, nrv:1, nrt:2, nrd:16'h0107, default:'0},
    '{adv:1, atag:3, aval:8'd7, rr:1, qv:1, qw:1, qa:8'd5, qt:0, qd:16'hAAAA, nqv:1, nqw:1, nqt:0, default:'0},
    '{sdv:1, stag:3, sval:16'hBBBB, rr:1, rv:1, rt:1, rd:16'hAAAA, rf:1, nqv:1, nqt:1, default:'0},
    '{rr:1, qv:1, qw:1, qa:8'd7, qt:3, qd:16'hBBBB, nqv:1, nqw:1, nqt:3, nrv:1, nrt:1, nrd:16'hAAAA, default:'0},
    '{ret:1, ar:1, rr:1, default:'0},
    '{ret:1, ar:1, rr:1, default:'0},
    '{ret:1, ar:1, rr:1, default:'0},
    '{ret:1, ar:1, default:'0}
  };

  task automatic idle_in();
    alloc_valid = 0; alloc_store = 0; addr_valid = 0; sdata_valid = 0; retire_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_in(); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    idle_in();
    do_reset();
    // R1 reset state on both copies
    chk("R1 alloc_ready", f_ar, 1);
    chk("R1 alloc_tag", f_at, 0);
    chk("R1 retire_ready", f_rr, 0);
    chk("R1 req", f_qv, 0);
    chk("R1 res", f_rv, 0);
    chk("R1 nf alloc_ready", n_ar, 1);
    chk("R1 nf req", n_qv, 0);

    // Table walk
    foreach (TBL[i]) begin
      @(negedge clk);
      alloc_valid = TBL[i].av; alloc_store = TBL[i].ast;
      addr_valid = TBL[i].adv; addr_tag = TBL[i].atag; addr_value = TBL[i].aval;
      sdata_valid = TBL[i].sdv; sdata_tag = TBL[i].stag; sdata_value = TBL[i].sval;
      retire_valid = TBL[i].ret;
      if (TBL[i].av) chk("R2 alloc_tag order", f_at, 32'(i));
      step();
      chk("R2 alloc_ready", f_ar, TBL[i].ar);
      chk("R10 retire_ready", f_rr, TBL[i].rr);
      chk("R10 nf retire_ready", n_rr, TBL[i].rr);
      chk("R3 R6 R7 R8 req valid", f_qv, TBL[i].qv);
      if (TBL[i].qv) begin
        chk("R6 R8 req write", f_qw, TBL[i].qw);
        chk("R7 R8 req addr", f_qa, TBL[i].qa);
        chk("R7 R8 req tag", f_qt, TBL[i].qt);
        if (TBL[i].qw) chk("R6 req data", f_qd, TBL[i].qd);
      end
      chk("R5 R9 res valid", f_rv, TBL[i].rv);
      if (TBL[i].rv) begin
        chk("R5 R9 res tag", f_rt, TBL[i].rt);
        chk("R5 R9 res data", f_rd, TBL[i].rd);
        chk("R5 R9 res fwd", f_rf, TBL[i].rf);
      end
      chk("R4 R6 nf req valid", n_qv, TBL[i].nqv);
      if (TBL[i].nqv) begin
        chk("R4 nf req write", n_qw, TBL[i].nqw);
        chk("R4 nf req tag", n_qt, TBL[i].nqt);
      end
      chk("R4 R9 nf res valid", n_rv, TBL[i].nrv);
      if (TBL[i].nrv) begin
        chk("R4 R9 nf res tag", n_rt, TBL[i].nrt);
        chk("R4 R9 nf res data", n_rd, TBL[i].nrd);
        chk("R4 R9 nf res fwd", n_rf, 0);
      end
    end
    @(negedge clk); idle_in();

    // R2 full queue: four loads, then an allocation offered while full
    do_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); alloc_valid = 1; alloc_store = 0;
      step();
    end
    chk("R2 full alloc_ready", f_ar, 0);
    @(negedge clk); alloc_valid = 1; alloc_store = 1;
    step();
    chk("R2 full ignored tag", f_at, 0);
    chk("R2 full still", f_ar, 0);
    rec = 1; fq_n = 0; fr_n = 0; nq_n = 0; nr_n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle_in(); addr_valid = 1; addr_tag = IW'(k); addr_value = AW'(8'h10 + k);
      step();
    end
    @(negedge clk); idle_in();
    repeat (6) step();
    chk("R7 four loads served", fr_n, 4);
    chk("R7 nf four loads served", nr_n, 4);
    chk("R9 load data", fr_d[3], 16'h0103);
    @(negedge clk); retire_valid = 1;
    step();
    chk("R10 retire frees slot", f_ar, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); retire_valid = 1;
      step();
    end
    @(negedge clk); idle_in();
    step();
    chk("R10 empty retire_ready", f_rr, 0);
    chk("R2 empty alloc_ready", f_ar, 1);
    rec = 0;

    // R5 youngest matching store: two stores then a load, one address
    do_reset();
    rec = 1; fq_n = 0; fr_n = 0; nq_n = 0; nr_n = 0;
    @(negedge clk); alloc_valid = 1; alloc_store = 1;
    @(negedge clk); alloc_valid = 1; alloc_store = 1;
    @(negedge clk); alloc_valid = 1; alloc_store = 0;
    @(negedge clk); idle_in(); addr_valid = 1; addr_tag = 0; addr_value = 8'd9;
    sdata_valid = 1; sdata_tag = 0; sdata_value = 16'h1111;
    @(negedge clk); addr_tag = 1; sdata_tag = 1; sdata_value = 16'h2222;
    @(negedge clk); idle_in(); addr_valid = 1; addr_tag = 2; addr_value = 8'd9;
    @(negedge clk); idle_in();
    repeat (8) step();
    rec = 0;
    chk("R5 fwd copy request count", fq_n, 2);
    chk("R8 older store first", fq_t[0], 0);
    chk("R8 younger store second", fq_t[1], 1);
    chk("R5 one forwarded result", fr_n, 1);
    chk("R5 youngest store data", fr_d[0], 16'h2222);
    chk("R5 forwarded flag", fr_f[0], 1);
    chk("R4 nf request count", nq_n, 3);
    chk("R4 nf load after stores", nq_t[2], 2);
    chk("R4 nf load is read", nq_w[2], 0);
    chk("R4 nf load data", nr_d[0], 16'h2222);
    chk("R4 nf not forwarded", nr_f[0], 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule